// File: doc/BRIEF.md
# Byte-Lane Parity Memory Error Register

This block sits in the path between a bus master and a word-wide memory. On every write it computes one odd-parity bit for each byte lane and hands data, byte enables and parity to the memory. On every returned read it checks each lane against its stored parity bit. Failures are recorded per lane in a control/status byte, together with the word address of the failing read. When interrupts are enabled, a pending flag is set and drives a non-maskable interrupt request.

Software controls three modes through the status byte: parity checking on or off, interrupt on or off, and a diagnostic mode. The diagnostic mode stores inverted parity so that a later read of that word fails on purpose. The first error freezes the flags and the address. They stay frozen until software writes the control word, and that write also clears the flags and the pending bit.

The memory must return read data with `mem_rvalid_i` exactly one cycle after the read request. The block latches the request address for that returning data.

Top module: `mem_parity_guard`

## Requirements
- R1: On a write, `mem_wpar_o[i]` is the odd-parity bit of lane i of `wdata_i`, that is, the inverse of the XOR of the lane's 8 bits. Lane i is data bits 8i+7..8i. For example, data 0x000103FF gives parity 4'b1011.
- R2: While the test bit (control word bit 29) is 1, every lane's write parity is inverted. For the same example data this gives 4'b0100.
- R3: When a read returns with the check-enable bit (control word bit 28) set, each lane whose 8 data bits and parity bit hold an even number of ones sets error flag bit 24+i of the control word.
- R4: When check-enable is 0, parity mismatches on reads record nothing and raise no request.
- R5: The pending bit (control word bit 31) and `nmi_o` are set with a recorded error only if interrupt-enable (bit 30) was 1 at that time. Otherwise both stay 0.
- R6: The address word (`reg_sel_i`=1) returns the word address of the failing read, zero-extended.
- R7: After the first recorded error, later failing reads change neither the flags nor the address nor the pending bit.
- R8: A register write with `reg_sel_i`=0 loads bits 30:28 into the control bits and clears the flags and the pending bit. The other data bits are ignored. Writes with `reg_sel_i`=1 are ignored.
- R9: A read with no mismatch leaves the whole control word unchanged.
- R10: Read data passes through unchanged: `rdata_o`/`rvalid_o` follow `mem_rdata_i`/`mem_rvalid_i`.
- R11: After reset, both register words read 0 and `nmi_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Master write request |
| rd_en_i | input | 1 | Master read request |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | LANES | Byte enables |
| rdata_o | output | DATA_W | Read data to master |
| rvalid_o | output | 1 | Read data valid |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_be_o | output | LANES | Memory byte enables |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_wpar_o | output | LANES | Memory write parity, one bit per lane |
| mem_rvalid_i | input | 1 | Memory read data valid, one cycle after request |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_rpar_i | input | LANES | Memory read parity |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the control word, 1 selects the address word |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with its defaults: 32-bit data, 8-bit lanes and a 12-bit word address, which gives four lanes and a status byte in bits 31:24. A 16-word memory model in the bench covers lane-selective writes, diagnostic inverted-parity writes and deliberate parity corruption. With these, every single-lane and multi-lane failure pattern can be produced, with every combination of check-enable and interrupt-enable. The freeze rule, the register-write priority and the ignored write bits are reached through directed sequences on the same four lanes.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int REG_W = 32;

  typedef struct packed {
    logic int_en;
    logic test_inv;
    logic chk_en;
  } mpg_ctrl_t;
endpackage

// File: rtl/mpg_par_gen.sv
module mpg_par_gen #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              inv_i,
  output logic [LANES-1:0]  par_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par_o[i] = ~(^data_i[i*LANE_W +: LANE_W]) ^ inv_i;
  end
endmodule

// File: rtl/mpg_par_chk.sv
module mpg_par_chk #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  par_i,
  output logic [LANES-1:0]  mism_o
);
  // odd parity: an even count of ones over data and parity is a failure
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mism_o[i] = valid_i & ~(^{par_i[i], data_i[i*LANE_W +: LANE_W]});
  end
endmodule

// File: rtl/mpg_err_reg.sv
module mpg_err_reg
  import mpg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [LANES-1:0]  mism_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output mpg_ctrl_t         ctrl_o,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              nmi_o
);
  localparam int STAT_W = 4 + LANES;
  localparam int PAD_W  = REG_W - STAT_W;

  mpg_ctrl_t         ctrl_q;
  logic [LANES-1:0]  flags_q;
  logic [ADDR_W-1:0] addr_q;
  logic              pend_q;
  logic              ctrl_wr;
  logic              rec;
  logic              unused_wbits;

  assign ctrl_wr = reg_we_i & ~reg_sel_i;
  assign rec     = ctrl_q.chk_en & (|mism_i) & (flags_q == '0);
  assign unused_wbits = ^{reg_wdata_i[REG_W-1], reg_wdata_i[REG_W-5:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      addr_q  <= '0;
      pend_q  <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q  <= reg_wdata_i[REG_W-2 -: 3];
      flags_q <= '0;
      pend_q  <= 1'b0;
    end else if (rec) begin
      flags_q <= mism_i;
      addr_q  <= rd_addr_i;
      pend_q  <= ctrl_q.int_en;
    end
  end

  assign ctrl_o = ctrl_q;
  assign nmi_o  = pend_q;

  always_comb begin
    if (reg_sel_i) reg_rdata_o = REG_W'(addr_q);
    else reg_rdata_o = {pend_q, ctrl_q.int_en, ctrl_q.test_inv, ctrl_q.chk_en,
                        flags_q, {PAD_W{1'b0}}};
  end

  AST_CHK_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.chk_en && flags_q == '0) |=> (flags_q == '0)); // R4
  AST_PEND_NEEDS_INTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(ctrl_q.int_en)); // R5
  AST_PEND_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (flags_q != '0)); // R5
  AST_ADDR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|flags_q) |-> (addr_q == $past(rd_addr_i))); // R6
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q != '0 && !ctrl_wr) |=> ($stable(flags_q) && $stable(addr_q) && $stable(pend_q))); // R7
  AST_CLEAR_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (flags_q == '0 && !pend_q)); // R8
endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 12,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_wpar_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [LANES-1:0]  mem_rpar_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              nmi_o
);
  mpg_ctrl_t         ctrl;
  logic [LANES-1:0]  mism;
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_addr_q <= '0;
    else if (rd_en_i) rd_addr_q <= addr_i;
  end

  assign mem_we_o    = wr_en_i;
  assign mem_re_o    = rd_en_i;
  assign mem_addr_o  = addr_i;
  assign mem_be_o    = be_i;
  assign mem_wdata_o = wdata_i;
  assign rdata_o     = mem_rdata_i;
  assign rvalid_o    = mem_rvalid_i;

  mpg_par_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_gen (
    .data_i (wdata_i),
    .inv_i  (ctrl.test_inv),
    .par_o  (mem_wpar_o)
  );

  mpg_par_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
    .valid_i (mem_rvalid_i),
    .data_i  (mem_rdata_i),
    .par_i   (mem_rpar_i),
    .mism_o  (mism)
  );

  mpg_err_reg #(.LANES(LANES), .ADDR_W(ADDR_W)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .mism_i      (mism),
    .rd_addr_i   (rd_addr_q),
    .ctrl_o      (ctrl),
    .reg_rdata_o (reg_rdata_o),
    .nmi_o       (nmi_o)
  );

  AST_WRITE_PAR_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !ctrl.test_inv) |-> (^{mem_wpar_o, mem_wdata_o} == (LANES % 2 == 1))); // R1
endmodule

// File: tb/mem_parity_guard_tb.sv
`timescale 1ns/1ps
module mem_parity_guard_tb;
  localparam int DW = 32, LW = 8, AW = 12, NL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          wr_en = 0, rd_en = 0, reg_we = 0, reg_sel = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, reg_wdata = '0;
  logic [NL-1:0] be = '0;
  logic [DW-1:0] rdata, mem_wdata, reg_rdata;
  logic          rvalid, mem_we, mem_re, nmi;
  logic [AW-1:0] mem_addr;
  logic [NL-1:0] mem_be, mem_wpar;
  logic          m_rv = 0;
  logic [DW-1:0] m_rd = '0;
  logic [NL-1:0] m_rp = '0;

  mem_parity_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .rvalid_o(rvalid),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_wpar_o(mem_wpar), .mem_rvalid_i(m_rv),
    .mem_rdata_i(m_rd), .mem_rpar_i(m_rp), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .nmi_o(nmi)
  );

  logic [DW-1:0] mdat [16];
  logic [NL-1:0] mpar [16];

  always @(posedge clk) begin
    if (mem_we)
      for (int l = 0; l < NL; l++)
        if (mem_be[l]) begin
          mdat[mem_addr[3:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
          mpar[mem_addr[3:0]][l] <= mem_wpar[l];
        end
    m_rv <= mem_re;
    if (mem_re) begin
      m_rd <= mdat[mem_addr[3:0]];
      m_rp <= mpar[mem_addr[3:0]];
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(logic sel, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_sel = 0;
  endtask

  task automatic reg_read(logic sel, output logic [31:0] d);
    reg_sel = sel; #0.5; d = reg_rdata; reg_sel = 0;
  endtask

  task automatic mem_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [NL-1:0] b);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; be = b;
    @(negedge clk); wr_en = 0; be = '0;
  endtask

  task automatic mem_read(logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; #0.5; d = rdata; v = rvalid;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0]    ctrl;   // {int_en, test, chk_en}
    logic [NL-1:0] be;
    logic [NL-1:0] flags;
    logic          pend;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'b101, 4'hF, 4'hF, 1'b1},
    '{3'b001, 4'h1, 4'h1, 1'b0},
    '{3'b101, 4'h8, 4'h8, 1'b1},
    '{3'b100, 4'h6, 4'h0, 1'b0},
    '{3'b101, 4'h0, 4'h0, 1'b0},
    '{3'b101, 4'h5, 4'h5, 1'b1},
    '{3'b001, 4'hA, 4'hA, 1'b0},
    '{3'b000, 4'hF, 4'h0, 1'b0}
  };

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] r, r2;
    logic [DW-1:0] d, base, d2, expd;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reg_read(0, r); check("R11 ctrl word", r, 0);
    reg_read(1, r); check("R11 addr word", r, 0);
    check("R11 nmi", {31'b0, nmi}, 0);

    // vector walk
    for (int i = 0; i < 8; i++) begin
      base = 32'h1357_9BDF ^ (i * 32'h0101_0101);
      d2   = ~base;
      reg_write(0, 0);
      mem_write(AW'(i), base, 4'hF);
      reg_write(0, 32'h2000_0000);
      mem_write(AW'(i), d2, VECS[i].be);
      reg_write(0, {1'b0, VECS[i].ctrl, 28'b0});
      mem_read(AW'(i), d, v);
      expd = base;
      for (int l = 0; l < NL; l++) if (VECS[i].be[l]) expd[l*8 +: 8] = d2[l*8 +: 8];
      check("R10 rdata", d, expd);
      check("R10 rvalid", {31'b0, v}, 1);
      reg_read(0, r);
      check("R3/R4 flags", {28'b0, r[27:24]}, {28'b0, VECS[i].flags});
      check("R5 pending", {31'b0, r[31]}, {31'b0, VECS[i].pend});
      check("R5 nmi", {31'b0, nmi}, {31'b0, VECS[i].pend});
      if (VECS[i].flags != 0) begin
        reg_read(1, r); check("R6 addr word", r, i);
      end
    end

    // R1 / R2 write parity
    reg_write(0, 0);
    @(negedge clk); wr_en = 1; addr = 15; wdata = 32'h0001_03FF; be = 4'hF; #0.5;
    check("R1 odd parity", {28'b0, mem_wpar}, 32'hB);
    @(negedge clk); wr_en = 0;
    reg_write(0, 32'h2000_0000);
    @(negedge clk); wr_en = 1; addr = 15; #0.5;
    check("R2 inverted parity", {28'b0, mem_wpar}, 32'h4);
    @(negedge clk); wr_en = 0;

    // R9 clean read, R7 freeze
    reg_write(0, 0);
    mem_write(12, 32'hA5A5_0F0F, 4'hF);
    mem_write(13, 32'h1234_5678, 4'hF);
    mem_write(14, 32'hCAFE_F00D, 4'hF);
    reg_write(0, 32'h5000_0000);
    mem_read(14, d, v);
    reg_read(0, r); check("R9 clean read unchanged", r, 32'h5000_0000);
    @(negedge clk); mpar[12][1] = ~mpar[12][1]; mpar[13][2] = ~mpar[13][2];
    mem_read(12, d, v);
    reg_read(0, r); check("R3 single lane flag", r, 32'hD200_0000);
    reg_read(1, r); check("R6 addr latched", r, 12);
    mem_read(13, d, v);
    reg_read(0, r); check("R7 flags frozen", r, 32'hD200_0000);
    reg_read(1, r); check("R7 addr frozen", r, 12);
    mem_read(14, d, v);
    reg_read(0, r); check("R9 clean read after error", r, 32'hD200_0000);

    // R8 write handling
    reg_write(1, 32'hFFFF_FFFF);
    reg_read(1, r); check("R8 addr word write ignored", r, 12);
    reg_read(0, r2); check("R8 ctrl unchanged by addr write", r2, 32'hD200_0000);
    reg_write(0, 32'h5FFF_FFFF);
    reg_read(0, r); check("R8 clear and ignored bits", r, 32'h5000_0000);
    check("R8 nmi cleared", {31'b0, nmi}, 0);

    // R5 error with interrupt disabled
    reg_write(0, 32'h1000_0000);
    mem_read(13, d, v);
    reg_read(0, r); check("R5 no pend without enable", r, 32'h1400_0000);
    check("R5 nmi low", {31'b0, nmi}, 0);

    summary();
  end
endmodule